// File: doc/BRIEF.md
# UART Receive Character Queue

This block buffers characters coming out of a UART receive deserializer. Every accepted character is written into a first-in first-out store together with three error flags: break detected, parity error and framing error. Software, or the bus bridge acting for it, takes characters out one at a time through a read strobe. Each read returns a word that holds the character, its flags and a valid bit.

Three receive conditions are tracked: overrun, fill level above a programmable threshold, and data left waiting longer than a programmable number of character times. Each condition has its own enable bit. The interrupt line is the OR of the enabled conditions that are pending. A configuration write sets the threshold, the timeout length and the enables. A separate one-cycle clear strobe empties the queue and drops the overrun flag.

The character time reaches the block as a one-cycle tick, so the timeout counter counts ticks. Reset is synchronous and active high. All outputs come from registers and change on the clock edge that samples the causing input.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds up to DEPTH (16) entries. `fill_level` is the number of stored entries, and `stat_not_empty` is high exactly when `fill_level` is non-zero. Both update on the edge that samples a push or pop.
- R2: Entries are read in arrival order. The read word has the character in bits 7:0, the valid bit in bit 8, the framing error in bit 9, the parity error in bit 10 and the break flag in bit 11. `rd_word` updates on the edge that samples `rd_req` and holds its value otherwise.
- R3: A read while the queue is empty returns an all-zero word, so the valid bit is clear, and leaves `fill_level` unchanged.
- R4: A character that arrives while the queue is full and no read is accepted in the same cycle is dropped and sets `stat_overrun`. If a read and a character arrive together while the queue is full, both are accepted and the fill stays at DEPTH.
- R5: Once set, `stat_overrun` stays set through reads. Only `fifo_clear` or reset clears it.
- R6: In one cycle, `fifo_clear` empties the queue and clears the overrun and timeout status. A character or read arriving in the same cycle is discarded.
- R7: `stat_thresh` is high exactly when `fill_level` is strictly greater than the programmed threshold. The threshold resets to DEPTH/2.
- R8: The tick counter restarts on every accepted push or pop and stays at zero while the queue is empty. `stat_timeout` rises once the counter reaches the programmed count, which resets to 1. A count of 0 disables the timeout.
- R9: `irq` is the OR of the pending conditions whose enable bit is set. Enable bit 0 gates overrun, bit 1 gates threshold and bit 2 gates timeout. The enables reset to zero.
- R10: After reset the queue is empty and `stat_overrun`, `stat_thresh`, `stat_timeout` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Strobe: a received character is present |
| rx_char | input | CHAR_W | Received character |
| rx_brk | input | 1 | Break detected for this character |
| rx_par | input | 1 | Parity error for this character |
| rx_frm | input | 1 | Framing error for this character |
| char_tick | input | 1 | One-cycle pulse per character time |
| cfg_wr | input | 1 | Load threshold, timeout count and enables |
| cfg_thresh | input | LVL_W | Fill threshold |
| cfg_timeout | input | TMO_W | Timeout length in ticks, 0 disables |
| cfg_irq_en | input | 3 | Interrupt enables: overrun, threshold, timeout |
| fifo_clear | input | 1 | Empty the queue and clear overrun |
| rd_req | input | 1 | Pop-on-read strobe |
| rd_word | output | CHAR_W+4 | Flags, valid bit and character of the popped entry |
| fill_level | output | LVL_W | Stored entry count |
| stat_not_empty | output | 1 | Queue holds data |
| stat_overrun | output | 1 | A character was lost (sticky) |
| stat_thresh | output | 1 | Fill level above threshold |
| stat_timeout | output | 1 | Data waited too long |
| irq | output | 1 | Enabled pending receive conditions, ORed |

## Verification
The hardest state to reach from the ports is a full queue that accepts a push and a pop in the same cycle, because the overrun rule must then stay silent. The stimulus fills the queue with sixteen numbered characters and forces an overrun with a seventeenth. It then checks that a read still returns the oldest character while overrun stays set. After topping the queue back up to full, it drives a character and a read in the same cycle. A clear that coincides with an arrival is also driven, and a follow-up read shows that the arrival was discarded.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;
  // bit positions of the interrupt enables / pending vector
  localparam int IDX_OVR = 0;
  localparam int IDX_THR = 1;
  localparam int IDX_TMO = 2;
  localparam int N_COND  = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 12,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic              rd_strobe,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [LVL_W-1:0]  level_q,
  output logic [LVL_W-1:0]  level_nx
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_comb begin
    level_nx = level_q;
    if (clr) level_nx = '0;
    else if (push && !pop) level_nx = level_q + LVL_W'(1);
    else if (pop && !push) level_nx = level_q - LVL_W'(1);
  end

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      rdata   <= '0;
    end else begin
      level_q <= level_nx;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr);
        if (pop)  rd_ptr <= bump(rd_ptr);
      end
      if (rd_strobe) rdata <= pop ? mem[rd_ptr] : '0;
    end
  end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire_nx
);
  logic [TMO_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (restart || !active) cnt_nx = '0;
    else if (tick && cnt_q != {TMO_W{1'b1}}) cnt_nx = cnt_q + TMO_W'(1);
  end

  assign expire_nx = (limit != '0) && (cnt_nx >= limit);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int LVL_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     ovr_event,
  input  logic                     tmo_nx,
  input  logic [LVL_W-1:0]         level_nx,
  input  logic [LVL_W-1:0]         thr_nx,
  input  logic [rxq_pkg::N_COND-1:0] en_nx,
  output logic                     not_empty,
  output logic                     ovr,
  output logic                     thr,
  output logic                     tmo,
  output logic                     irq
);
  import rxq_pkg::*;
  logic [N_COND-1:0] pend_nx;
  logic              ovr_nx;

  assign ovr_nx = clr ? 1'b0 : (ovr | ovr_event);

  always_comb begin
    pend_nx          = '0;
    pend_nx[IDX_OVR] = ovr_nx;
    pend_nx[IDX_THR] = level_nx > thr_nx;
    pend_nx[IDX_TMO] = tmo_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      not_empty <= 1'b0;
      ovr       <= 1'b0;
      thr       <= 1'b0;
      tmo       <= 1'b0;
      irq       <= 1'b0;
    end else begin
      not_empty <= level_nx != '0;
      ovr       <= ovr_nx;
      thr       <= pend_nx[IDX_THR];
      tmo       <= pend_nx[IDX_TMO];
      irq       <= |(pend_nx & en_nx);
    end
  end
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH   = 16,
  parameter int TMO_W   = 8,
  localparam int CHAR_W = rxq_pkg::CHAR_W,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int WORD_W = CHAR_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_brk,
  input  logic              rx_par,
  input  logic              rx_frm,
  input  logic              char_tick,
  input  logic              cfg_wr,
  input  logic [LVL_W-1:0]  cfg_thresh,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [2:0]        cfg_irq_en,
  input  logic              fifo_clear,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_word,
  output logic [LVL_W-1:0]  fill_level,
  output logic              stat_not_empty,
  output logic              stat_overrun,
  output logic              stat_thresh,
  output logic              stat_timeout,
  output logic              irq
);
  import rxq_pkg::*;

  logic [LVL_W-1:0]  thr_q, thr_nx, level_nx;
  logic [TMO_W-1:0]  tmo_q, tmo_nx;
  logic [N_COND-1:0] en_q, en_nx;
  logic              full, pop_ok, push_ok, ovr_event, expire_nx;
  logic [WORD_W-1:0] wword;

  always_comb begin
    thr_nx = cfg_wr ? cfg_thresh  : thr_q;
    tmo_nx = cfg_wr ? cfg_timeout : tmo_q;
    en_nx  = cfg_wr ? cfg_irq_en  : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= LVL_W'(DEPTH / 2);
      tmo_q <= TMO_W'(1);
      en_q  <= '0;
    end else begin
      thr_q <= thr_nx;
      tmo_q <= tmo_nx;
      en_q  <= en_nx;
    end
  end

  assign full      = fill_level == LVL_W'(DEPTH);
  assign pop_ok    = rd_req && !fifo_clear && (fill_level != '0);
  assign push_ok   = rx_valid && !fifo_clear && (!full || pop_ok);
  assign ovr_event = rx_valid && !fifo_clear && full && !pop_ok;
  assign wword     = {rx_brk, rx_par, rx_frm, 1'b1, rx_char};

  rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .clr(fifo_clear),
    .push(push_ok), .pop(pop_ok), .rd_strobe(rd_req),
    .wdata(wword), .rdata(rd_word),
    .level_q(fill_level), .level_nx(level_nx)
  );

  rxq_timeout #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst),
    .restart(push_ok || pop_ok || fifo_clear),
    .active(fill_level != '0),
    .tick(char_tick), .limit(tmo_nx),
    .expire_nx(expire_nx)
  );

  rxq_status #(.LVL_W(LVL_W)) u_status (
    .clk(clk), .rst(rst), .clr(fifo_clear),
    .ovr_event(ovr_event), .tmo_nx(expire_nx),
    .level_nx(level_nx), .thr_nx(thr_nx), .en_nx(en_nx),
    .not_empty(stat_not_empty), .ovr(stat_overrun),
    .thr(stat_thresh), .tmo(stat_timeout), .irq(irq)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5,
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              fifo_clear,
  input logic              rd_req,
  input logic [WORD_W-1:0] rd_word,
  input logic [LVL_W-1:0]  fill_level,
  input logic              stat_not_empty,
  input logic              stat_overrun,
  input logic              stat_thresh,
  input logic              stat_timeout,
  input logic              irq
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_level <= LVL_W'(DEPTH)); // R1
  AST_NOT_EMPTY_AGREES: assert property (@(posedge clk) disable iff (rst)
    stat_not_empty == (fill_level != '0)); // R1
  AST_EMPTY_READ_INVALID: assert property (@(posedge clk) disable iff (rst)
    (rd_req && fill_level == '0 && !rx_valid && !fifo_clear) |=> (!rd_word[8] && fill_level == '0)); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_overrun && !fifo_clear) |=> stat_overrun); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (fill_level == '0 && !stat_overrun && !stat_timeout)); // R6
  AST_THRESH_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    stat_thresh |-> stat_not_empty); // R7
  AST_TIMEOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    stat_timeout |-> stat_not_empty); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_overrun || stat_thresh || stat_timeout)); // R9
endmodule

bind rx_char_queue rxq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .WORD_W(WORD_W)) u_rxq_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .fifo_clear(fifo_clear),
  .rd_req(rd_req), .rd_word(rd_word), .fill_level(fill_level),
  .stat_not_empty(stat_not_empty), .stat_overrun(stat_overrun),
  .stat_thresh(stat_thresh), .stat_timeout(stat_timeout), .irq(irq)
);

// File: tb/test_rx_char_queue.sv
module test_rx_char_queue;
  localparam int DEPTH = 16;
  localparam int TMO_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_brk = 1'b0, rx_par = 1'b0, rx_frm = 1'b0;
  logic [7:0] rx_char = '0;
  logic char_tick = 1'b0, cfg_wr = 1'b0, fifo_clear = 1'b0, rd_req = 1'b0;
  logic [LVL_W-1:0] cfg_thresh = '0;
  logic [TMO_W-1:0] cfg_timeout = '0;
  logic [2:0] cfg_irq_en = '0;
  logic [11:0] rd_word;
  logic [LVL_W-1:0] fill_level;
  logic stat_not_empty, stat_overrun, stat_thresh, stat_timeout, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  rx_char_queue #(.DEPTH(DEPTH), .TMO_W(TMO_W)) i_rx_char_queue (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_par(rx_par), .rx_frm(rx_frm), .char_tick(char_tick),
    .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh), .cfg_timeout(cfg_timeout),
    .cfg_irq_en(cfg_irq_en), .fifo_clear(fifo_clear), .rd_req(rd_req),
    .rd_word(rd_word), .fill_level(fill_level), .stat_not_empty(stat_not_empty),
    .stat_overrun(stat_overrun), .stat_thresh(stat_thresh),
    .stat_timeout(stat_timeout), .irq(irq)
  );

  // {brk, par, frm, char}
  localparam logic [10:0] VEC [6] = '{
    11'h041, {3'b100, 8'h00}, {3'b010, 8'h55},
    {3'b001, 8'hC3}, {3'b111, 8'hFF}, {3'b000, 8'h7E}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c, input logic b, input logic p, input logic f);
    rx_valid = 1'b1; rx_char = c; rx_brk = b; rx_par = p; rx_frm = f;
    @(negedge clk);
    rx_valid = 1'b0; rx_brk = 1'b0; rx_par = 1'b0; rx_frm = 1'b0;
  endtask

  task automatic pop();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      char_tick = 1'b1;
      @(negedge clk);
      char_tick = 1'b0;
    end
  endtask

  task automatic config_wr(input logic [LVL_W-1:0] th, input logic [TMO_W-1:0] to,
                           input logic [2:0] en);
    cfg_wr = 1'b1; cfg_thresh = th; cfg_timeout = to; cfg_irq_en = en;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "fill", 32'(fill_level), 0);
    chk("R10", "not_empty", 32'(stat_not_empty), 0);
    chk("R10", "overrun", 32'(stat_overrun), 0);
    chk("R10", "thresh", 32'(stat_thresh), 0);
    chk("R10", "timeout/irq", 32'({stat_timeout, irq}), 0);

    config_wr(LVL_W'(4), '0, 3'b000);
    for (int i = 0; i < 6; i++) push(VEC[i][7:0], VEC[i][10], VEC[i][9], VEC[i][8]);
    chk("R1", "fill after 6", 32'(fill_level), 6);
    chk("R7", "thresh at 6>4", 32'(stat_thresh), 1);
    for (int i = 0; i < 6; i++) begin
      pop();
      chk("R2", "word order/format", 32'(rd_word),
          32'({VEC[i][10:8], 1'b1, VEC[i][7:0]}));
      chk("R7", "thresh vs fill", 32'(stat_thresh), 32'((5 - i) > 4));
    end
    chk("R1", "empty after drain", 32'({stat_not_empty, fill_level}), 0);

    pop();
    chk("R3", "empty read word", 32'(rd_word), 0);
    chk("R3", "empty read fill", 32'(fill_level), 0);

    for (int i = 0; i < DEPTH; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    chk("R1", "full fill", 32'(fill_level), DEPTH);
    chk("R4", "no overrun when just full", 32'(stat_overrun), 0);
    push(8'hAA, 1'b0, 1'b0, 1'b0);
    chk("R4", "overrun set", 32'(stat_overrun), 1);
    chk("R4", "dropped char, fill", 32'(fill_level), DEPTH);
    pop();
    chk("R5", "oldest survives", 32'(rd_word), 32'h100);
    chk("R5", "overrun kept after read", 32'(stat_overrun), 1);
    push(8'h10, 1'b0, 1'b0, 1'b0);
    rx_valid = 1'b1; rx_char = 8'h11; rd_req = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rd_req = 1'b0;
    chk("R4", "push+pop at full fill", 32'(fill_level), DEPTH);
    chk("R4", "push+pop at full word", 32'(rd_word), 32'h101);

    rx_valid = 1'b1; rx_char = 8'h5A; fifo_clear = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; fifo_clear = 1'b0;
    chk("R6", "clear fill", 32'(fill_level), 0);
    chk("R6", "clear overrun", 32'(stat_overrun), 0);
    pop();
    chk("R6", "arrival discarded", 32'(rd_word), 0);

    config_wr(LVL_W'(8), TMO_W'(3), 3'b100);
    push(8'h31, 1'b0, 1'b0, 1'b0);
    ticks(2);
    chk("R8", "timeout before limit", 32'(stat_timeout), 0);
    ticks(1);
    chk("R8", "timeout at limit", 32'(stat_timeout), 1);
    chk("R9", "irq from timeout", 32'(irq), 1);
    push(8'h32, 1'b0, 1'b0, 1'b0);
    chk("R8", "push restarts timer", 32'(stat_timeout), 0);
    chk("R9", "irq drops", 32'(irq), 0);
    config_wr(LVL_W'(8), TMO_W'(3), 3'b000);
    ticks(3);
    chk("R8", "timeout pending again", 32'(stat_timeout), 1);
    chk("R9", "masked timeout no irq", 32'(irq), 0);
    config_wr(LVL_W'(8), TMO_W'(0), 3'b100);
    chk("R8", "count 0 disables", 32'(stat_timeout), 0);
    ticks(4);
    chk("R8", "stays disabled", 32'(stat_timeout), 0);
    config_wr(LVL_W'(1), TMO_W'(0), 3'b010);
    chk("R9", "irq from thresh", 32'({stat_thresh, irq}), 3);
    config_wr(LVL_W'(1), TMO_W'(0), 3'b001);
    chk("R9", "overrun enable alone", 32'(irq), 0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "reset empties", 32'({stat_not_empty, fill_level}), 0);
    report();
  end
endmodule